// File: doc/BRIEF.md
# Quadrature Position Decoder with Revolution Count

This block turns two phase signals from an incremental encoder, plus an optional index mark, into a 16-bit position word. The position word has two parts. The low bits hold an angular count whose width can be set from 9 to 16 bits. The bits above it hold a revolution count. When the angular part wraps, the revolution part moves by one. An optional period value can lower the top of the angular range, which suits encoders whose line count is not a power of two.

Each of the three inputs (phase A, phase B, index) comes either from a device pin or from an internal event line. A pin source can have its active level inverted. Phases A and B can be exchanged, for an encoder wired in reverse. Decoding runs at x4 resolution, where every phase edge counts, or at x2, where only edges of phase A count. A single-input counter mode uses input 0 alone and counts its rising active edges.

Top module: `qdec_revcount`

## Requirements
- R1: After reset, `count` is 0, `dirDown` is 0 and `revWrap` is 0.
- R2: Input i (bit 0 = phase A, bit 1 = phase B, bit 2 = index) comes from `pinIn[i]` when `pinEn[i]` is 1 and from `evtIn[i]` when `pinEn[i]` is 0. The unselected source has no effect on `count`.
- R3: `pinInv[i]` inverts input i only while `pinEn[i]` is 1. With `pinEn[i]` at 0, the event line is used as is.
- R4: In x4 mode (`x2Mode`=0), each change of exactly one phase moves the angular count by one. The phase order (A,B) = 00,10,11,01 counts up and the reverse order counts down. `dirDown` holds the sign of the last step: 1 for down, 0 for up.
- R5: In x2 mode (`x2Mode`=1), only changes of phase A count, using the same sign rule. Changes of phase B alone leave `count` unchanged.
- R6: If A and B change in the same sample, `count` does not change.
- R7: While `swapEn` is 1 in quadrature mode, phases A and B trade sources. In counter mode `swapEn` has no effect.
- R8: The angular part is the low 9+`angularSel` bits of `count`, and the revolution part is the bits above it. Counting up from the angular maximum gives angular 0 and adds 1 to the revolution part, and `revWrap` pulses for one cycle. With `angularSel`=7 the whole word is angular.
- R9: Counting down from angular 0 gives the angular maximum, subtracts 1 from the revolution part, and pulses `revWrap`.
- R10: With `periodEn`=1, the angular maximum is `periodVal` masked to the angular width. With `periodEn`=0, the angular maximum is all ones.
- R11: In counter mode (`modeCounter`=1), each rising active edge of input 0 adds one to `count`, following the same wrap rules. Inputs 1 and 2 are ignored.
- R12: In quadrature mode, a rising active edge of the index input clears the angular part and leaves the revolution part unchanged.
- R13: Inputs pass through two synchronizing flops and one edge register. `count` reflects an input change on the third rising clock edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 3 | Pin inputs {index, B, A} |
| evtIn | input | 3 | Event-line inputs {index, B, A} |
| pinEn | input | 3 | Per-input source select, 1 = pin |
| pinInv | input | 3 | Per-input pin polarity invert |
| swapEn | input | 1 | Exchange phases A and B |
| modeCounter | input | 1 | 1 = single-input counter mode, 0 = quadrature |
| x2Mode | input | 1 | 1 = x2 decoding, 0 = x4 |
| angularSel | input | 3 | Angular width selector (width = 9 + value) |
| periodEn | input | 1 | Use periodVal as angular maximum |
| periodVal | input | 16 | Angular period value |
| count | output | 16 | Position word {revolutions, angle} |
| dirDown | output | 1 | Direction of the last step, 1 = down |
| revWrap | output | 1 | One-cycle pulse on angular wrap |

## Verification
The bench counts through the full angular range for the three narrowest widths, then steps back across zero. A design that carried into the revolution part at the wrong bit, or did not borrow on the way down, would show a wrong word right at the wrap. Periodic ranges are checked with a 16-bit angular part, where there is no revolution field to carry into, and with a 12-bit angular part. These catch a period that is not masked, or a carry into revolution bits that do not exist. The bench also covers simultaneous phase changes, swapped phases, x2 decoding, and which source and inversion are selected. A decoder that accepted a double change, let unselected pins leak through, or inverted event lines would drift from the computed position.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
    logic clrAng;
  } stepT;
endpackage

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N_IN-1:0] pinIn,
  input  logic [N_IN-1:0] evtIn,
  input  logic [N_IN-1:0] pinEn,
  input  logic [N_IN-1:0] pinInv,
  input  logic            swapEn,
  input  logic            modeCounter,
  input  logic            x2Mode,
  output stepT            step
);
  logic [N_IN-1:0] chosen, mapped, metaS, stableS, prevS;

  // source selection; inversion only applies to pin sources
  for (genvar i = 0; i < N_IN; i++) begin : g_src
    assign chosen[i] = pinEn[i] ? (pinIn[i] ^ pinInv[i]) : evtIn[i];
  end

  always_comb begin
    mapped = chosen;
    if (swapEn && !modeCounter) begin
      mapped[0] = chosen[1];
      mapped[1] = chosen[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaS   <= '0;
      stableS <= '0;
      prevS   <= '0;
    end else begin
      metaS   <= mapped;
      stableS <= metaS;
      prevS   <= stableS;
    end
  end

  logic chA, chB, upDir, validQ;
  assign chA    = stableS[0] ^ prevS[0];
  assign chB    = stableS[1] ^ prevS[1];
  assign upDir  = stableS[0] ^ prevS[1];
  assign validQ = x2Mode ? (chA && !chB) : (chA ^ chB);

  always_comb begin
    step = '0;
    if (modeCounter) begin
      step.inc = stableS[0] && !prevS[0];
    end else begin
      step.clrAng = stableS[2] && !prevS[2];
      step.inc    = validQ && upDir;
      step.dec    = validQ && !upDir;
    end
  end
endmodule

// File: rtl/qdec_dpath.sv
module qdec_dpath
  import qdec_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ANG_BASE = 9,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepT             step,
  input  logic [SEL_W-1:0] angularSel,
  input  logic             periodEn,
  input  logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             revWrap
);
  int               angW;
  logic [CNT_W-1:0] angMask, revUnit, angCur, revCur, angTop, nextCnt;
  logic             wrapN;

  always_comb begin
    angW    = ANG_BASE + int'(angularSel);
    angMask = CNT_W'((33'd1 << angW) - 33'd1);
    revUnit = CNT_W'(33'd1 << angW);
    angCur  = count & angMask;
    revCur  = count & ~angMask;
    angTop  = periodEn ? (periodVal & angMask) : angMask;
    nextCnt = count;
    wrapN   = 1'b0;
    if (step.clrAng) begin
      nextCnt = revCur;
    end else if (step.inc) begin
      if (angCur >= angTop) begin
        nextCnt = revCur + revUnit;
        wrapN   = 1'b1;
      end else begin
        nextCnt = count + 1'b1;
      end
    end else if (step.dec) begin
      if (angCur == '0) begin
        nextCnt = (revCur - revUnit) | angTop;
        wrapN   = 1'b1;
      end else begin
        nextCnt = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      dirDown <= 1'b0;
      revWrap <= 1'b0;
    end else begin
      count   <= nextCnt;
      revWrap <= wrapN;
      if (step.dec && !step.clrAng) dirDown <= 1'b1;
      else if (step.inc && !step.clrAng) dirDown <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_revcount.sv
module qdec_revcount
  import qdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  pinIn,
  input  logic [2:0]  evtIn,
  input  logic [2:0]  pinEn,
  input  logic [2:0]  pinInv,
  input  logic        swapEn,
  input  logic        modeCounter,
  input  logic        x2Mode,
  input  logic [2:0]  angularSel,
  input  logic        periodEn,
  input  logic [15:0] periodVal,
  output logic [15:0] count,
  output logic        dirDown,
  output logic        revWrap
);
  stepT stepS;

  qdec_ctrl #(.N_IN(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .evtIn(evtIn), .pinEn(pinEn),
    .pinInv(pinInv), .swapEn(swapEn), .modeCounter(modeCounter),
    .x2Mode(x2Mode), .step(stepS)
  );

  qdec_dpath #(.CNT_W(16), .ANG_BASE(9), .SEL_W(3)) dpath_i (
    .clk(clk), .rstN(rstN), .step(stepS), .angularSel(angularSel),
    .periodEn(periodEn), .periodVal(periodVal), .count(count),
    .dirDown(dirDown), .revWrap(revWrap)
  );
endmodule

// File: rtl/qdec_revcount_chk.sv
module qdec_revcount_chk
  import qdec_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input stepT        step,
  input logic [2:0]  angularSel,
  input logic [15:0] count,
  input logic        dirDown,
  input logic        revWrap
);
  logic [15:0] mask;
  assign mask = 16'((33'd1 << (9 + int'(angularSel))) - 33'd1);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!step.inc && !step.dec && !step.clrAng) |=> $stable(count)); // R4

  AST_INC_DEC_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(step.inc && step.dec)); // R6

  AST_DIR_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (step.dec && !step.clrAng) |=> dirDown); // R4

  AST_DIR_UP: assert property (@(posedge clk) disable iff (!rstN)
    (step.inc && !step.clrAng) |=> !dirDown); // R4

  AST_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(revWrap) |-> $past(step.inc || step.dec)); // R8

  AST_WRAP_UP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (revWrap && $past(step.inc) && $stable(angularSel)) |-> ((count & mask) == 16'd0)); // R8
endmodule

bind qdec_revcount qdec_revcount_chk chk_i (
  .clk(clk), .rstN(rstN), .step(stepS), .angularSel(angularSel),
  .count(count), .dirDown(dirDown), .revWrap(revWrap)
);

// File: tb/qdec_revcount_tb.sv
module qdec_revcount_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  pinIn = '0, evtIn = '0, pinEn = 3'b111, pinInv = '0;
  logic        swapEn = 0, modeCounter = 0, x2Mode = 0, periodEn = 0;
  logic [2:0]  angularSel = '0;
  logic [15:0] periodVal = '0;
  logic [15:0] count;
  logic        dirDown, revWrap;

  int compared = 0, mismatched = 0, wrapSeen = 0, q = 0;
  bit srcEvt = 0;
  logic [15:0] expCnt;

  always #5 clk = ~clk;

  qdec_revcount dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .evtIn(evtIn), .pinEn(pinEn),
    .pinInv(pinInv), .swapEn(swapEn), .modeCounter(modeCounter),
    .x2Mode(x2Mode), .angularSel(angularSel), .periodEn(periodEn),
    .periodVal(periodVal), .count(count), .dirDown(dirDown), .revWrap(revWrap)
  );

  always @(negedge clk) if (rstN && revWrap) wrapSeen++;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0; pinIn = '0; evtIn = '0; q = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1; wrapSeen = 0; expCnt = '0;
    settle();
  endtask

  function automatic logic [15:0] model(input logic [15:0] c, input int dir,
                                        output bit w);
    int angMod = 1 << (9 + int'(angularSel));
    int ang = int'(c) % angMod;
    int rv = int'(c) / angMod;
    int revMod = 65536 / angMod;
    int topA = periodEn ? (int'(periodVal) % angMod) : angMod - 1;
    w = 0;
    if (dir > 0) begin
      if (ang >= topA) begin ang = 0; rv++; w = 1; end else ang++;
    end else begin
      if (ang == 0) begin ang = topA; rv--; w = 1; end else ang--;
    end
    rv = ((rv % revMod) + revMod) % revMod;
    return 16'(rv * angMod + ang);
  endfunction

  task automatic driveAB(input logic a, input logic b);
    if (srcEvt) begin evtIn[0] = a; evtIn[1] = b; end
    else begin pinIn[0] = a; pinIn[1] = b; end
    settle();
  endtask

  // drive one quadrature step in bench order 00,10,11,01 (up)
  task automatic qStep(input int dir);
    q = (q + dir + 4) % 4;
    driveAB(q == 1 || q == 2, q == 2 || q == 3);
  endtask

  task automatic upExp(input int dir);
    bit w;
    expCnt = model(expCnt, dir, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    doReset();
    check("R1 count", count, 0);
    check("R1 dirDown", dirDown, 0);
    check("R1 revWrap", revWrap, 0);

    // R13 latency: count changes on third edge
    pinIn[0] = 1; q = 1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R13 before", count, 0);
    @(posedge clk); @(negedge clk);
    check("R13 after", count, 1);
    settle();
    doReset();

    // R4 R8 R9 full sweeps over narrow angular widths
    for (int sel = 0; sel < 3; sel++) begin
      doReset();
      angularSel = 3'(sel);
      for (int s = 0; s < (1 << (9 + sel)); s++) begin
        qStep(1); upExp(1);
        check("R4 up", count, expCnt);
      end
      check("R8 carry", count, 1 << (9 + sel));
      check("R8 wraps", wrapSeen, 1);
      check("R4 dir up", dirDown, 0);
      qStep(-1); upExp(-1);
      check("R9 borrow", count, (1 << (9 + sel)) - 1);
      check("R9 wraps", wrapSeen, 2);
      check("R4 dir down", dirDown, 1);
    end

    // R9 down from zero at sel 0
    doReset(); angularSel = 0;
    for (int s = 0; s < 3; s++) begin qStep(-1); upExp(-1); end
    check("R9 below zero", count, 16'hFFFD);

    // R10 period with full-width angular (R8 no revolutions)
    doReset(); angularSel = 7; periodEn = 1; periodVal = 20;
    for (int s = 0; s < 21; s++) begin qStep(1); upExp(1); end
    check("R10 period wrap sel7", count, 0);
    check("R8 no rev sel7", wrapSeen, 1);
    qStep(-1);
    check("R10 period down", count, 20);
    doReset(); angularSel = 3; periodVal = 16'hF064; // masked to 100
    for (int s = 0; s < 101; s++) begin qStep(1); upExp(1); end
    check("R10 masked period", count, 16'h1000);
    periodEn = 0; periodVal = 0; angularSel = 0;

    // R6 simultaneous change ignored
    doReset();
    qStep(1); qStep(1);
    check("R6 pre", count, 2);
    q = 0; driveAB(0, 0);
    check("R6 double change", count, 2);
    qStep(1);
    check("R6 resumes", count, 3);

    // R5 x2 mode
    doReset(); x2Mode = 1;
    for (int s = 0; s < 8; s++) qStep(1);
    check("R5 x2 full cycles", count, 4);
    q = 0; driveAB(0, 1); driveAB(0, 0);
    check("R5 B only", count, 4);
    x2Mode = 0;

    // R7 swap reverses sense in quadrature
    doReset(); swapEn = 1;
    for (int s = 0; s < 5; s++) qStep(1);
    check("R7 swapped", count, 16'hFFFB);
    check("R7 swapped dir", dirDown, 1);
    while (q != 0) qStep(1);
    swapEn = 0;

    // R2 R3 event source, inversion ignored without pin enable
    doReset(); pinEn = 3'b000; pinInv = 3'b111; srcEvt = 1;
    for (int s = 0; s < 6; s++) qStep(1);
    check("R2 R3 event source", count, 6);
    pinIn = 3'b011; settle(); pinIn = 3'b000; settle();
    check("R2 pins ignored", count, 6);
    while (q != 0) qStep(1);
    srcEvt = 0; pinInv = 0; pinEn = 3'b111;

    // R12 index clears angle, keeps revolutions
    doReset(); angularSel = 0; periodEn = 1; periodVal = 9;
    for (int s = 0; s < 13; s++) qStep(1);
    check("R12 pre", count, 16'h0203);
    pinIn[2] = 1; settle();
    check("R12 index", count, 16'h0200);
    pinIn[2] = 0; settle();
    check("R12 index fall", count, 16'h0200);
    periodEn = 0; periodVal = 0;

    // R11 counter mode, R7 swap no effect, R3 pin inversion
    doReset(); modeCounter = 1; swapEn = 1;
    for (int s = 0; s < 5; s++) begin
      pinIn[0] = 1; settle(); pinIn[0] = 0; settle();
    end
    check("R11 counts", count, 5);
    pinIn[1] = 1; pinIn[2] = 1; settle(); pinIn[1] = 0; pinIn[2] = 0; settle();
    check("R11 others ignored R7", count, 5);
    pinInv[0] = 1; settle();
    expCnt = count;
    pinIn[0] = 1; settle();
    check("R3 inverted no count on rise", count, expCnt);
    pinIn[0] = 0; settle();
    check("R3 inverted counts on fall", count, expCnt + 1);
    pinEn[0] = 0; settle();
    expCnt = count;
    evtIn[0] = 1; settle(); evtIn[0] = 0; settle();
    check("R3 event not inverted", count, expCnt + 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule